// File: doc/BRIEF.md
# Glitch-Filtered Slow/Fast Clock Divider

The block derives three clocks from an oscillator-rate input clock: a CPU clock, a companion clock with near-equal high and low times, and a peripheral clock. The CPU clock and the companion clock divide the oscillator by 3 in fast mode and by 768 in slow mode. The peripheral clock always divides by 6. A raw speed-select pin chooses the mode. That pin passes through a two-stage synchronizer and then an asymmetric persistence filter. A long run of low samples is needed to slow down, and only a short run of high samples is needed to speed up again.

Entry into slow mode takes effect only at the end of a CPU clock period. Return to fast mode takes effect on the next peripheral clock edge, and the CPU divider restarts at the start of its high phase on that edge. A hold input from a halt controller parks the CPU divider at the start of its high phase, so the CPU and companion clocks rest high. The peripheral clock keeps running. The hold behaves the same way in both speed modes. All outputs are decoded from registered counters.

Top module: `slowfast_clkgen`

## Requirements
- R1: In fast mode `cpu_clk_o` has a period of 3 oscillator cycles, high for 1 and low for 2. `sq_clk_o` is high for 2 and low for 1.
- R2: In slow mode `cpu_clk_o` is high for 256 cycles and low for 512. `sq_clk_o` is high for 384 and low for 384.
- R3: `per_clk_o` is high for 3 cycles and low for 3 in either mode.
- R4: `speed_sel_i` low requests slow mode and high requests fast mode. Slow mode is accepted only after 195 consecutive low samples of the input. A low run of 194 samples or fewer leaves the block in fast mode.
- R5: Fast mode is accepted only after 6 consecutive high samples. A high run of 5 samples or fewer leaves the block in slow mode.
- R6: On a return to fast mode, `slow_o` falls in the same cycle in which `per_clk_o` toggles, and `cpu_clk_o` is high in that cycle. The fall is seen 9 to 11 cycles after the input rises.
- R7: Slow mode begins at a CPU period boundary. In the first cycle with `slow_o` high, `cpu_clk_o` starts a full 256-cycle high phase.
- R8: While `hold_i` is high, the CPU divider runs on to the start of its high phase and stays there. `cpu_clk_o` and `sq_clk_o` then rest high and `per_clk_o` keeps toggling. This is the same in both modes. After `hold_i` is released, the divider resumes at the rate of the current mode.
- R9: While reset is asserted the block is in fast mode with cleared filters. `cpu_clk_o`, `sq_clk_o` and `per_clk_o` are all high and `slow_o` is low.
- R10: `slow_o` is high exactly while the dividers run at the slow rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| speed_sel_i | input | 1 | Raw speed select, 1 = fast, 0 = slow |
| hold_i | input | 1 | Stop-hold request from the halt controller |
| cpu_clk_o | output | 1 | CPU clock (1/3 duty) |
| sq_clk_o | output | 1 | Companion clock, near-equal high/low |
| per_clk_o | output | 1 | Peripheral clock, oscillator / 6 |
| slow_o | output | 1 | Current mode indicator, 1 = slow |

## Verification
The fast-mode switch and the hold can act in the same cycle. A return to fast mode forces the CPU divider to phase zero, and the hold keeps it parked at phase zero. To provoke this, the bench parks the divider in slow mode and raises the speed select while `hold_i` is still high. The bench then checks three things: `slow_o` falls on a peripheral clock edge, the CPU and companion clocks stay high until the hold is released, and the first measured period after release has fast timing.

// File: rtl/slowfast_pkg.sv
package slowfast_pkg;
  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOW = 1'b1
  } speed_e;

  function automatic int unsigned high_len(input int unsigned div);
    return div / 3;
  endfunction

  function automatic int unsigned sq_len(input int unsigned div);
    return (div + 1) / 2;
  endfunction
endpackage

// File: rtl/speed_sync.sv
module speed_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/speed_filter.sv
module speed_filter
  import slowfast_pkg::*;
#(
  parameter int unsigned SLOW_QUAL = 195,
  parameter int unsigned FAST_QUAL = 6
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   in_i,
  output speed_e tgt_o
);
  localparam int unsigned LO_W = $clog2(SLOW_QUAL + 1);
  localparam int unsigned HI_W = $clog2(FAST_QUAL + 1);
  localparam logic [LO_W-1:0] LO_TOP = LO_W'(SLOW_QUAL - 1);
  localparam logic [HI_W-1:0] HI_TOP = HI_W'(FAST_QUAL - 1);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  speed_e          tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      tgt_q <= MODE_FAST;
    end else if (!in_i) begin
      hi_q <= '0;
      if (lo_q == LO_TOP) tgt_q <= MODE_SLOW;
      else                lo_q  <= lo_q + 1'b1;
    end else begin
      lo_q <= '0;
      if (hi_q == HI_TOP) tgt_q <= MODE_FAST;
      else                hi_q  <= hi_q + 1'b1;
    end
  end

  assign tgt_o = tgt_q;

  // R4
  slow_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_q == MODE_SLOW) |-> ($past(lo_q) == LO_TOP) && !$past(in_i));
  // R5
  fast_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_q == MODE_SLOW) |-> ($past(hi_q) == HI_TOP) && $past(in_i));
  // R4
  lo_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_q <= LO_TOP);
endmodule

// File: rtl/per_div.sv
module per_div #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic per_clk_o,
  output logic edge_o
);
  localparam int unsigned PC_W = $clog2(DIV);
  localparam logic [PC_W-1:0] HALF = PC_W'(DIV / 2);
  localparam logic [PC_W-1:0] LAST = PC_W'(DIV - 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pc_q <= '0;
    else if (pc_q == LAST) pc_q <= '0;
    else                   pc_q <= pc_q + 1'b1;
  end

  assign per_clk_o = pc_q < HALF;
  // asserted in the cycle before per_clk_o toggles
  assign edge_o    = (pc_q == HALF - 1'b1) || (pc_q == LAST);

  // R3
  pc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= LAST);
  // R3
  per_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (per_clk_o != $past(per_clk_o)));
endmodule

// File: rtl/cpu_div.sv
module cpu_div
  import slowfast_pkg::*;
#(
  parameter int unsigned FAST_DIV = 3,
  parameter int unsigned SLOW_DIV = 768
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  speed_e tgt_i,
  input  logic   hold_i,
  input  logic   pedge_i,
  output logic   cpu_clk_o,
  output logic   sq_clk_o,
  output logic   slow_o
);
  localparam int unsigned PH_W = $clog2(SLOW_DIV);
  localparam logic [PH_W-1:0] F_LAST = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0] S_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0] F_CPU  = PH_W'(high_len(FAST_DIV));
  localparam logic [PH_W-1:0] S_CPU  = PH_W'(high_len(SLOW_DIV));
  localparam logic [PH_W-1:0] F_SQ   = PH_W'(sq_len(FAST_DIV));
  localparam logic [PH_W-1:0] S_SQ   = PH_W'(sq_len(SLOW_DIV));

  logic [PH_W-1:0] ph_q;
  logic            slow_q;
  logic [PH_W-1:0] last, cpu_len, sq_len_w;
  logic            fast_go, park;

  always_comb begin
    last     = slow_q ? S_LAST : F_LAST;
    cpu_len  = slow_q ? S_CPU  : F_CPU;
    sq_len_w = slow_q ? S_SQ   : F_SQ;
    fast_go  = slow_q && (tgt_i == MODE_FAST) && pedge_i;
    park     = hold_i && (ph_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      slow_q <= 1'b0;
    end else if (fast_go) begin
      ph_q   <= '0;
      slow_q <= 1'b0;
    end else if (!park) begin
      if (ph_q == last) begin
        ph_q   <= '0;
        // slow entry only at a period boundary; exit only via fast_go
        slow_q <= slow_q | (tgt_i == MODE_SLOW);
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign cpu_clk_o = ph_q < cpu_len;
  assign sq_clk_o  = ph_q < sq_len_w;
  assign slow_o    = slow_q;

  // R7
  slow_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_q) |-> (ph_q == '0) && $past(ph_q) == S_LAST - (S_LAST - F_LAST));
  // R6
  fast_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slow_q) |-> $past(pedge_i) && (ph_q == '0));
  // R8
  hold_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && ph_q == '0) |=> (ph_q == '0));
  // R1
  fast_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_q |-> (ph_q <= F_LAST));
endmodule

// File: rtl/slowfast_clkgen.sv
module slowfast_clkgen
  import slowfast_pkg::*;
#(
  parameter int unsigned FAST_DIV  = 3,
  parameter int unsigned SLOW_DIV  = 768,
  parameter int unsigned PER_DIV   = 6,
  parameter int unsigned SLOW_QUAL = 195,
  parameter int unsigned FAST_QUAL = 6,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_sel_i,
  input  logic hold_i,
  output logic cpu_clk_o,
  output logic sq_clk_o,
  output logic per_clk_o,
  output logic slow_o
);
  logic   sel_sync;
  speed_e tgt;
  logic   pedge;

  speed_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (speed_sel_i),
    .q_o   (sel_sync)
  );

  speed_filter #(.SLOW_QUAL(SLOW_QUAL), .FAST_QUAL(FAST_QUAL)) i_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (sel_sync),
    .tgt_o (tgt)
  );

  per_div #(.DIV(PER_DIV)) i_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_clk_o(per_clk_o),
    .edge_o   (pedge)
  );

  cpu_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_cpu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt),
    .hold_i   (hold_i),
    .pedge_i  (pedge),
    .cpu_clk_o(cpu_clk_o),
    .sq_clk_o (sq_clk_o),
    .slow_o   (slow_o)
  );

  // R10
  slow_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_o) |-> $past(tgt == MODE_SLOW));
endmodule

// File: tb/test_slowfast_clkgen.sv
module test_slowfast_clkgen;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic speed_sel_i = 1'b1;
  logic hold_i = 1'b0;
  logic cpu_clk_o, sq_clk_o, per_clk_o, slow_o;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #2 clk_i = ~clk_i;

  slowfast_clkgen i_slowfast_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed_sel_i(speed_sel_i),
    .hold_i     (hold_i),
    .cpu_clk_o  (cpu_clk_o),
    .sq_clk_o   (sq_clk_o),
    .per_clk_o  (per_clk_o),
    .slow_o     (slow_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(input int div, input bit sq);
    return sq ? (div + 1) / 2 : div / 3;
  endfunction

  function automatic logic sig(input int s);
    case (s)
      0:       return cpu_clk_o;
      1:       return sq_clk_o;
      2:       return per_clk_o;
      default: return slow_o;
    endcase
  endfunction

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic measure(input int s, output int hi, output int lo);
    logic prev;
    int   guard = 0;
    prev = sig(s);
    step();
    while (!(prev == 1'b0 && sig(s) == 1'b1) && guard < 5000) begin
      prev = sig(s);
      step();
      guard++;
    end
    hi = 0;
    while (sig(s) == 1'b1 && hi < 5000) begin hi++; step(); end
    lo = 0;
    while (sig(s) == 1'b0 && lo < 5000) begin lo++; step(); end
  endtask

  task automatic check_div(input int div, input string req);
    int hi, lo;
    measure(0, hi, lo);
    chk(hi == exp_hi(div, 0), {req, " cpu high"}, hi, exp_hi(div, 0));
    chk(lo == div - exp_hi(div, 0), {req, " cpu low"}, lo, div - exp_hi(div, 0));
    measure(1, hi, lo);
    chk(hi == exp_hi(div, 1), {req, " sq high"}, hi, exp_hi(div, 1));
    chk(lo == div - exp_hi(div, 1), {req, " sq low"}, lo, div - exp_hi(div, 1));
    measure(2, hi, lo);
    chk(hi == 3 && lo == 3, "R3 per high+low", hi * 10 + lo, 33);
  endtask

  task automatic wait_slow(input logic v, output int w);
    w = 0;
    while (slow_o != v && w < 2000) begin step(); w++; end
  endtask

  task automatic held_window(input string req);
    int bad = 0;
    int tog = 0;
    logic p;
    p = per_clk_o;
    for (int i = 0; i < 30; i++) begin
      if (!(cpu_clk_o && sq_clk_o)) bad++;
      step();
      if (per_clk_o != p) tog++;
      p = per_clk_o;
    end
    chk(bad == 0, {req, " clocks rest high"}, bad, 0);
    chk(tog >= 9, {req, " per clock keeps running"}, tog, 10);
  endtask

  initial begin
    int w, cnt, bad;
    logic pp;
    void'($urandom(32'h5EED));
    repeat (3) step();
    // R9
    chk(cpu_clk_o && sq_clk_o && per_clk_o && !slow_o, "R9 reset state",
        {cpu_clk_o, sq_clk_o, per_clk_o, slow_o}, 4'b1110);
    rst_ni = 1'b1;
    repeat (2) step();

    // R1 R3 fast timing
    check_div(3, "R1");

    // R4 a run of 194 low samples is ignored
    speed_sel_i = 1'b0;
    repeat (194) step();
    speed_sel_i = 1'b1;
    repeat (1100) step();
    chk(slow_o == 1'b0, "R4 194 low ignored", slow_o, 0);

    // R4 R7 195 low samples accepted, entry on period boundary
    speed_sel_i = 1'b0;
    wait_slow(1'b1, w);
    chk(slow_o == 1'b1 && w <= 1000, "R4 195 low accepted", w, 970);
    chk(w >= 196, "R4 not accepted early", w, 196);
    cnt = 0;
    while (cpu_clk_o && cnt < 1000) begin cnt++; step(); end
    chk(cnt == 256, "R7 first slow high phase full", cnt, 256);

    // R2 R3 R10 slow timing
    check_div(768, "R2");
    chk(slow_o == 1'b1, "R10 slow indicator", slow_o, 1);

    // R5 a 5-sample high pulse is ignored
    speed_sel_i = 1'b1;
    repeat (5) step();
    speed_sel_i = 1'b0;
    repeat (100) step();
    chk(slow_o == 1'b1, "R5 5 high ignored", slow_o, 1);

    // R8 hold in slow mode
    hold_i = 1'b1;
    repeat (800) step();
    held_window("R8 slow");

    // R6 R8 fast switch while held
    speed_sel_i = 1'b1;
    pp = per_clk_o;
    w = 0;
    while (slow_o && w < 60) begin pp = per_clk_o; step(); w++; end
    chk(!slow_o && per_clk_o != pp, "R6 switch on per edge while held", per_clk_o, !pp);
    held_window("R8 held after switch");
    hold_i = 1'b0;
    check_div(3, "R8 resume fast");

    // R6 switch to fast, latency and alignment
    speed_sel_i = 1'b0;
    wait_slow(1'b1, w);
    repeat (50) step();
    speed_sel_i = 1'b1;
    pp = per_clk_o;
    w = 0;
    while (slow_o && w < 60) begin pp = per_clk_o; step(); w++; end
    chk(per_clk_o != pp, "R6 per toggles with switch", per_clk_o, !pp);
    chk(cpu_clk_o == 1'b1, "R6 cpu restarts high", cpu_clk_o, 1);
    chk(w >= 9 && w <= 11, "R5 R6 switch latency", w, 10);
    check_div(3, "R1 after switch");

    // R8 hold in fast mode
    hold_i = 1'b1;
    repeat (10) step();
    held_window("R8 fast");
    hold_i = 1'b0;
    check_div(3, "R8 resume");

    // R4 random short low runs never slow the clock
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      int lo_n, hi_n;
      lo_n = 1 + int'($urandom % 194);
      hi_n = 1 + int'($urandom % 20);
      speed_sel_i = 1'b0;
      for (int k = 0; k < lo_n; k++) begin step(); if (slow_o) bad++; end
      speed_sel_i = 1'b1;
      for (int k = 0; k < hi_n; k++) begin step(); if (slow_o) bad++; end
    end
    chk(bad == 0, "R4 random glitches", bad, 0);

    // R5 random short high runs never speed the clock
    speed_sel_i = 1'b0;
    wait_slow(1'b1, w);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      int lo_n, hi_n;
      hi_n = 1 + int'($urandom % 5);
      lo_n = 1 + int'($urandom % 300);
      speed_sel_i = 1'b1;
      for (int k = 0; k < hi_n; k++) begin step(); if (!slow_o) bad++; end
      speed_sel_i = 1'b0;
      for (int k = 0; k < lo_n; k++) begin step(); if (!slow_o) bad++; end
    end
    chk(bad == 0, "R5 random glitches", bad, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule